// File: doc/BRIEF.md
# Indirect Register-to-Bus Command Bridge

The bridge lets a host that only has a narrow window of 64-bit configuration registers reach a wider internal peripheral bus with 32-bit addresses. The host loads a 32-bit write value into a data register. It then writes one command word into the control register. The address, the byte count and the direction of the transfer all come from fields in that word, and the write launches a single request/acknowledge transaction on the internal bus straight away.

When the internal bus acknowledges, the bridge records the outcome in a status register. A completion flag is set, and for reads the returned word is packed into a fixed field. A failed read leaves all ones in that field. The host polls the status register. Each read of it returns the current value and empties it in the same access, so the next poll sees zero until another transaction completes.

Only one transaction can be outstanding. A second command that arrives while the bus has not yet acknowledged is stalled at the configuration port. Other register accesses go through normally, so the host can keep polling while the bus is busy.

Top module: `reg_bus_bridge`

## Requirements
- R1: The register is selected by bits [4:3] of cfg_addr (0 control, 1 reset, 2 status, 3 data); other address bits are ignored. Only accesses with cfg_bytes equal to 8 take effect. Any other size changes no state, launches nothing, and a read of that size returns zero.
- R2: An accepted 8-byte write to the control register raises bus_req on the next clock edge. bus_we is the inverse of word bit 48 (bit 48 set means read), bus_len is word bits [59:56], and bus_addr is word bits [31:0].
- R3: bus_req and all bus request fields hold steady until a cycle in which bus_ack is high; bus_req is low after that edge.
- R4: While bus_req is high, an 8-byte control write sees cfg_ready low and is not accepted; every other access is accepted with cfg_ready high. When the acknowledge edge has passed, the held command is accepted.
- R5: A data-register write stores bits [63:32] of cfg_wdata. A data-register read returns the stored word in bits [63:32] and zeros in bits [31:0].
- R6: During a bus write, bus_wdata is the data word captured at launch, with its most significant byte on bits [31:24]. Later data-register writes do not alter it.
- R7: When a bus write completes, status becomes exactly 0x0000_0000_0000_0800 (only the done flag, bit 11), whether or not bus_err was high.
- R8: When a bus read completes with bus_err low, status becomes the done flag (bit 11) plus bus_rdata placed in bits [57:26].
- R9: When a bus read completes with bus_err high, status becomes the done flag (bit 11) with all ones in bits [57:26].
- R10: An accepted status read returns the status value and clears it to zero. If a completion lands in the same cycle, the read returns the old value and the new result is kept.
- R11: Reads of the control and reset registers return zero. Writes to the reset and status registers change nothing.
- R12: After reset, cfg_ready is high, bus_req is low, and the status and data registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | CFG_AW | Configuration byte address |
| cfg_bytes | input | 4 | Access size in bytes |
| cfg_wdata | input | 64 | Write value |
| cfg_ready | output | 1 | Access accepted when high with cfg_valid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| cfg_rdata | output | 64 | Read data |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | Internal bus direction, 1 = write |
| bus_addr | output | 32 | Internal bus address |
| bus_len | output | 4 | Transfer size in bytes |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_err | input | 1 | Error response, sampled with bus_ack |
| bus_rdata | input | 32 | Internal bus read data |

## Verification
The bench targets the cycle in which a completion and a status read meet. A design that gives the clear priority there would lose a result for good. It stalls a command across the acknowledge edge: a bridge that drops the held command, or launches it on top of the live one, would leave bus_req or its fields wrong. It rewrites the data register while a bus write is pending, which catches a bridge that drives live data instead of a launch-time copy. It also sends wrong-size accesses and addresses with stray bits outside [4:3], where a bridge that decoded loosely would corrupt registers. Random transactions with mixed errors and acknowledge latencies check the bit-11 flag and the [57:26] field placement against values worked out in the bench.

// File: rtl/rbb_pkg.sv
package rbb_pkg;
  localparam int WORD_W     = 64;
  localparam int BUS_AW     = 32;
  localparam int BUS_DW     = 32;
  localparam int LEN_W      = 4;
  localparam int ACC_BYTES  = 8;
  localparam int CMD_RD_BIT = 48;
  localparam int LEN_LSB    = 56;
  localparam int DONE_BIT   = 11;
  localparam int RDF_LSB    = 26;
  localparam int DATA_LSB   = 32;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_RST  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } sel_e;

  typedef struct packed {
    logic              we;
    logic [LEN_W-1:0]  len;
    logic [BUS_AW-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/rbb_decode.sv
module rbb_decode
  import rbb_pkg::*;
#(
  parameter int CFG_AW  = 8,
  parameter int SEL_LSB = 3
) (
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_bytes,
  input  logic              busy,
  output logic              cfg_ready,
  output sel_e              sel,
  output logic              size_ok,
  output logic              ctl_wr,
  output logic              data_wr,
  output logic              stat_rd,
  output logic              rd_acc
);
  logic stall;
  logic acc;

  always_comb begin
    sel     = sel_e'(cfg_addr[SEL_LSB +: 2]);
    size_ok = (cfg_bytes == 4'(ACC_BYTES));
    stall   = busy && cfg_write && size_ok && (sel == SEL_CTL);
    cfg_ready = !stall;
    acc     = cfg_valid && !stall;
    ctl_wr  = acc && cfg_write && size_ok && (sel == SEL_CTL);
    data_wr = acc && cfg_write && size_ok && (sel == SEL_DATA);
    stat_rd = acc && !cfg_write && size_ok && (sel == SEL_STAT);
    rd_acc  = acc && !cfg_write;
  end
endmodule

// File: rtl/rbb_bus_master.sv
module rbb_bus_master
  import rbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [BUS_DW-1:0] wdata_src,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [BUS_DW-1:0] bus_rdata,
  output logic              busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [LEN_W-1:0]  bus_len,
  output logic [BUS_DW-1:0] bus_wdata,
  output logic              done,
  output logic              done_rd,
  output logic              done_err,
  output logic [BUS_DW-1:0] done_rdata
);
  logic              req_q, req_d;
  cmd_t              cmd_q, cmd_d;
  logic [BUS_DW-1:0] wd_q, wd_d;
  logic              cmd_en;

  // next state
  always_comb begin
    cmd_en = launch;
    cmd_d.we   = !cmd_word[CMD_RD_BIT];
    cmd_d.len  = cmd_word[LEN_LSB +: LEN_W];
    cmd_d.addr = cmd_word[BUS_AW-1:0];
    wd_d  = wdata_src;
    req_d = req_q;
    if (launch)
      req_d = 1'b1;
    else if (req_q && bus_ack)
      req_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cmd_q <= '0;
      wd_q  <= '0;
    end else begin
      req_q <= req_d;
      if (cmd_en) begin
        cmd_q <= cmd_d;
        wd_q  <= wd_d;
      end
    end
  end

  always_comb begin
    busy       = req_q;
    bus_req    = req_q;
    bus_we     = cmd_q.we;
    bus_addr   = cmd_q.addr;
    bus_len    = cmd_q.len;
    bus_wdata  = wd_q;
    done       = req_q && bus_ack;
    done_rd    = !cmd_q.we;
    done_err   = bus_err;
    done_rdata = bus_rdata;
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !bus_ack) |=> (req_q && $stable(cmd_q) && $stable(wd_q)));
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && bus_ack) |=> !req_q);
  p_no_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !launch);
endmodule

// File: rtl/rbb_regfile.sv
module rbb_regfile
  import rbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  logic              size_ok,
  input  logic              data_wr,
  input  logic              stat_rd,
  input  logic              rd_acc,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done,
  input  logic              done_rd,
  input  logic              done_err,
  input  logic [BUS_DW-1:0] done_rdata,
  output logic [BUS_DW-1:0] data_word,
  output logic              cfg_rvalid,
  output logic [WORD_W-1:0] cfg_rdata
);
  logic [WORD_W-1:0] stat_q, stat_d, stat_new;
  logic [BUS_DW-1:0] data_q, data_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  logic [BUS_DW-1:0] rd_field;
  logic              data_en, rdata_en;

  // next state
  always_comb begin
    rd_field = done_err ? '1 : done_rdata;
    stat_new = '0;
    stat_new[DONE_BIT] = 1'b1;
    if (done_rd)
      stat_new[RDF_LSB +: BUS_DW] = rd_field;

    stat_d = stat_q;
    if (done)
      stat_d = stat_new;
    else if (stat_rd)
      stat_d = '0;

    data_en = data_wr;
    data_d  = wdata[DATA_LSB +: BUS_DW];

    rdata_en = rd_acc;
    rdata_d  = '0;
    if (size_ok) begin
      unique case (sel)
        SEL_STAT: rdata_d = stat_q;
        SEL_DATA: rdata_d = {data_q, {(WORD_W-BUS_DW){1'b0}}};
        default:  rdata_d = '0;
      endcase
    end
    rvalid_d = rd_acc;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= '0;
      data_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      stat_q   <= stat_d;
      rvalid_q <= rvalid_d;
      if (data_en)  data_q  <= data_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign data_word  = data_q;
  assign cfg_rvalid = rvalid_q;
  assign cfg_rdata  = rdata_q;

  p_clear_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done) |=> (stat_q == '0));
  p_done_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat_q[DONE_BIT]);
  p_err_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_rd && done_err) |=> (&stat_q[RDF_LSB +: BUS_DW]));
  p_data_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (data_q == $past(wdata[DATA_LSB +: BUS_DW])));
endmodule

// File: rtl/reg_bus_bridge.sv
module reg_bus_bridge
  import rbb_pkg::*;
#(
  parameter int CFG_AW  = 8,
  parameter int SEL_LSB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [3:0]        cfg_bytes,
  input  logic [63:0]       cfg_wdata,
  output logic              cfg_ready,
  output logic              cfg_rvalid,
  output logic [63:0]       cfg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [31:0]       bus_addr,
  output logic [3:0]        bus_len,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [31:0]       bus_rdata
);
  sel_e              sel;
  logic              size_ok, ctl_wr, data_wr, stat_rd, rd_acc, busy;
  logic              done, done_rd, done_err;
  logic [BUS_DW-1:0] done_rdata, data_word;

  rbb_decode #(.CFG_AW(CFG_AW), .SEL_LSB(SEL_LSB)) u_dec (
    .cfg_valid (cfg_valid),
    .cfg_write (cfg_write),
    .cfg_addr  (cfg_addr),
    .cfg_bytes (cfg_bytes),
    .busy      (busy),
    .cfg_ready (cfg_ready),
    .sel       (sel),
    .size_ok   (size_ok),
    .ctl_wr    (ctl_wr),
    .data_wr   (data_wr),
    .stat_rd   (stat_rd),
    .rd_acc    (rd_acc)
  );

  rbb_bus_master u_mst (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (ctl_wr),
    .cmd_word   (cfg_wdata),
    .wdata_src  (data_word),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_len    (bus_len),
    .bus_wdata  (bus_wdata),
    .done       (done),
    .done_rd    (done_rd),
    .done_err   (done_err),
    .done_rdata (done_rdata)
  );

  rbb_regfile u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .size_ok    (size_ok),
    .data_wr    (data_wr),
    .stat_rd    (stat_rd),
    .rd_acc     (rd_acc),
    .wdata      (cfg_wdata),
    .done       (done),
    .done_rd    (done_rd),
    .done_err   (done_err),
    .done_rdata (done_rdata),
    .data_word  (data_word),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata)
  );
endmodule

// File: tb/sim_reg_bus_bridge.sv
`timescale 1ns/1ps
module sim_reg_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_valid, cfg_write, cfg_ready, cfg_rvalid;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_bytes;
  logic [63:0] cfg_wdata, cfg_rdata;
  logic        bus_req, bus_we, bus_ack, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_len;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [7:0] A_CTL = 8'h00, A_RST = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18;

  always #2 clk = ~clk;

  reg_bus_bridge u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_stat(input bit rd, input bit err, input logic [31:0] d);
    logic [63:0] s;
    s = 64'h800;
    if (rd) s[57:26] = err ? 32'hFFFF_FFFF : d;
    return s;
  endfunction

  function automatic logic [63:0] mk_cmd(input bit rd, input logic [3:0] len, input logic [31:0] a);
    logic [63:0] w;
    w = {$urandom, $urandom};
    w[48] = rd;
    w[59:56] = len;
    w[31:0] = a;
    return w;
  endfunction

  task automatic cfg_op(input bit w, input logic [7:0] a, input logic [3:0] b,
                        input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    cfg_valid = 1; cfg_write = w; cfg_addr = a; cfg_bytes = b; cfg_wdata = wd;
    #0.5;
    while (!cfg_ready) begin @(negedge clk); #0.5; end
    @(posedge clk);
    @(negedge clk);
    cfg_valid = 0;
    rd = cfg_rdata;
  endtask

  task automatic respond(input int lat, input bit err, input logic [31:0] d);
    repeat (lat) @(negedge clk);
    @(negedge clk);
    bus_ack = 1; bus_err = err; bus_rdata = d;
    @(negedge clk);
    bus_ack = 0; bus_err = 0; bus_rdata = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, cmd;
    logic [31:0] dmodel;
    cfg_valid = 0; cfg_write = 0; cfg_addr = 0; cfg_bytes = 8; cfg_wdata = 0;
    bus_ack = 0; bus_err = 0; bus_rdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R12 reset state
    chk("R12 ready", {63'b0, cfg_ready}, 64'd1);
    chk("R12 req", {63'b0, bus_req}, 64'd0);
    cfg_op(0, A_STAT, 8, 0, r); chk("R12 status", r, 0);
    cfg_op(0, A_DATA, 8, 0, r); chk("R12 data", r, 0);

    // R5 data register
    cfg_op(1, A_DATA, 8, 64'hA1B2C3D4_55667788, r);
    cfg_op(0, A_DATA, 8, 0, r); chk("R5 data read", r, 64'hA1B2C3D4_00000000);
    dmodel = 32'hA1B2C3D4;
    // R11 ctl / reset read zero
    cfg_op(0, A_CTL, 8, 0, r); chk("R11 ctl read", r, 0);
    cfg_op(0, A_RST, 8, 0, r); chk("R11 rst read", r, 0);

    // R1 stray address bits, wrong size
    cfg_op(1, 8'b1001_1101, 8, 64'h0BADF00D_00000000, r);
    cfg_op(0, A_DATA, 8, 0, r); chk("R1 addr bits [4:3]", r, 64'h0BADF00D_00000000);
    cfg_op(1, A_DATA, 4, 64'h12345678_00000000, r);
    cfg_op(0, A_DATA, 8, 0, r); chk("R1 bad size write ignored", r, 64'h0BADF00D_00000000);
    cfg_op(0, A_DATA, 2, 0, r); chk("R1 bad size read zero", r, 0);
    cfg_op(1, A_CTL, 4, mk_cmd(0, 4, 32'h1), r);
    chk("R1 bad size ctl no launch", {63'b0, bus_req}, 0);
    cfg_op(1, A_DATA, 8, 64'hA1B2C3D4_00000000, r);

    // R2 R6 R4 R7 write launch
    cmd = mk_cmd(0, 4'd4, 32'h1234_5678);
    cfg_op(1, A_CTL, 8, cmd, r);
    chk("R2 req", {63'b0, bus_req}, 1);
    chk("R2 we", {63'b0, bus_we}, 1);
    chk("R2 len", {60'b0, bus_len}, 4);
    chk("R2 addr", {32'b0, bus_addr}, 64'h1234_5678);
    chk("R6 wdata", {32'b0, bus_wdata}, 64'hA1B2C3D4);
    cfg_op(1, A_DATA, 8, 64'hFFEEDDCC_00000000, r);
    chk("R6 snapshot", {32'b0, bus_wdata}, 64'hA1B2C3D4);
    dmodel = 32'hFFEEDDCC;
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_addr = A_CTL; cfg_bytes = 8; cfg_wdata = mk_cmd(1, 4, 0);
    #0.5 chk("R4 ctl stalled", {63'b0, cfg_ready}, 0);
    cfg_valid = 0;
    cfg_op(0, A_STAT, 8, 0, r); chk("R4 poll while busy", r, 0);
    chk("R3 held", {63'b0, bus_req}, 1);
    respond(2, 1, 32'h0);
    chk("R3 dropped", {63'b0, bus_req}, 0);
    // R11 writes to status / reset ignored
    cfg_op(1, A_STAT, 8, 0, r);
    cfg_op(1, A_RST, 8, 64'hFFFF_FFFF_FFFF_FFFF, r);
    cfg_op(0, A_STAT, 8, 0, r); chk("R7/R11 write done status", r, 64'h800);
    cfg_op(0, A_STAT, 8, 0, r); chk("R10 cleared", r, 0);

    // R8 good read
    cfg_op(1, A_CTL, 8, mk_cmd(1, 4'd2, 32'hC001_0040), r);
    chk("R2 read we", {63'b0, bus_we}, 0);
    respond(0, 0, 32'hDEADBEEF);
    cfg_op(0, A_STAT, 8, 0, r); chk("R8 read status", r, exp_stat(1, 0, 32'hDEADBEEF));

    // R9 failed read
    cfg_op(1, A_CTL, 8, mk_cmd(1, 4'd4, 32'h5), r);
    respond(1, 1, 32'h1234);
    cfg_op(0, A_STAT, 8, 0, r); chk("R9 err read status", r, exp_stat(1, 1, 0));

    // R10 completion coincides with status read
    cfg_op(1, A_CTL, 8, mk_cmd(1, 4'd1, 32'h77), r);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_addr = A_STAT; cfg_bytes = 8;
    bus_ack = 1; bus_err = 0; bus_rdata = 32'h0000_00A5;
    @(negedge clk);
    cfg_valid = 0; bus_ack = 0;
    chk("R10 same-cycle old value", cfg_rdata, 0);
    cfg_op(0, A_STAT, 8, 0, r); chk("R10 same-cycle kept", r, exp_stat(1, 0, 32'hA5));

    // R4 stalled command across ack
    cfg_op(1, A_CTL, 8, mk_cmd(0, 4'd4, 32'hAAAA_0000), r);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_addr = A_CTL; cfg_bytes = 8;
    cfg_wdata = mk_cmd(1, 4'd8, 32'hBBBB_0001);
    bus_ack = 1;
    #0.5 chk("R4 stalled at ack", {63'b0, cfg_ready}, 0);
    @(negedge clk);
    bus_ack = 0;
    #0.5 chk("R4 ready after ack", {63'b0, cfg_ready}, 1);
    @(negedge clk);
    cfg_valid = 0;
    chk("R4 held cmd launched", {bus_req, bus_we, bus_len, 26'b0, bus_addr},
        {1'b1, 1'b0, 4'd8, 26'b0, 32'hBBBB_0001});
    respond(0, 0, 32'h3C3C_5A5A);
    cfg_op(0, A_STAT, 8, 0, r); chk("R8 after stall", r, exp_stat(1, 0, 32'h3C3C_5A5A));

    // random transactions
    void'($urandom(32'h5EED));
    for (int i = 0; i < 40; i++) begin
      bit rd, er;
      logic [31:0] a, d, rv;
      logic [3:0] ln;
      int lat;
      rd = 1'($urandom); er = ($urandom % 4) == 0;
      a = $urandom; d = $urandom; rv = $urandom; ln = 4'($urandom); lat = $urandom % 4;
      cfg_op(1, A_DATA, 8, {d, 32'($urandom)}, r);
      dmodel = d;
      cfg_op(1, A_CTL, 8, mk_cmd(rd, ln, a), r);
      chk("R2 rand fields", {bus_req, bus_we, bus_len, 26'b0, bus_addr},
          {1'b1, !rd, ln, 26'b0, a});
      if (!rd) chk("R6 rand wdata", {32'b0, bus_wdata}, {32'b0, dmodel});
      respond(lat, er, rv);
      cfg_op(0, A_STAT, 8, 0, r);
      chk(rd ? (er ? "R9 rand" : "R8 rand") : "R7 rand", r, exp_stat(rd, er, rv));
      cfg_op(0, A_STAT, 8, 0, r); chk("R10 rand clear", r, 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule